// File: doc/BRIEF.md
# Flash command sequence decoder

This block models the write-command front end of a byte-wide parallel NOR flash together with a small storage array. A write cycle is the interval during which chip-enable and write-enable are both low. The block takes the address when that interval opens and the data byte when it closes. Strict strings of unlock writes select one of three operations: byte program, chip erase or sector erase. The chosen operation is then handed to an embedded sequencer. The sequencer applies the change to the array over a parameterised number of clock cycles.

The array has `2**MEM_AW` bytes split into `SECTORS` equal sectors. A program can only clear bits. Erase sets a byte back to 0xFF, and every byte is driven to 0x00 just before it is erased. After a sector erase command, an acceptance window stays open for `WIN_CYC` cycles. More sector erase writes in that window add sectors and restart it. An erase of selected sectors can be suspended and resumed. All strobes are active low and are sampled on the system clock.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset every byte reads 0xFF, `busy`, `win_open` and `suspended` are 0, and `dout` is 0x00 whenever `oe_n` or `ce_n` is high.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data@A start a program. `busy` is 1 from the cycle after the last write until the byte at A has been updated.
- R3: A program stores the AND of the old byte and the written data, so a 0 bit never becomes 1.
- R4: A write that does not match the expected unlock address/data pair returns the decoder to read mode. The array does not change and `busy` stays 0.
- R5: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and 0x30@S raise `win_open`. Once `WIN_CYC` cycles pass without a write, the sector of S is erased to 0xFF and the other sectors are left untouched.
- R6: Each 0x30 write while `win_open` is high adds the sector of its address and restarts the window.
- R7: Any other data value written while `win_open` is high closes the window with no erase.
- R8: The same six-write string with 0x10@0x555 as its last write erases every sector to 0xFF.
- R9: During a sector erase, 0xB0 suspends the erase (`suspended`=1, `busy` stays 1, no progress) and 0x30 resumes it. All other writes during the erase are ignored.
- R10: A byte being erased is first written 0x00. Shortly after a chip erase starts, byte 0 reads 0x00.
- R11: The address of a write cycle is the one present when the cycle opens. Later changes before the cycle closes have no effect.
- R12: A write cycle closes on whichever of `ce_n` and `we_n` rises first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| ce_n | input | 1 | chip enable, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| addr | input | ADDR_W | byte address |
| din | input | 8 | write data |
| dout | output | 8 | read data, 0x00 when not enabled |
| busy | output | 1 | embedded operation running |
| win_open | output | 1 | sector erase acceptance window open |
| suspended | output | 1 | sector erase held |

## Verification
The assertions assume that strobes change only between clock edges and that a write cycle is held open for at least one full clock. They also assume that `din` is stable at the edge where the cycle closes. The stimulus meets this by driving every input on the falling clock edge. Each write holds both strobes low for one full cycle and lets them rise on separate cycles, with data held unchanged. The bench never places a write in the final cycle of the erase window, because there the expiry and a new sector write would collide.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [10:0] UL_ADDR_A = 11'h555;
  localparam logic [10:0] UL_ADDR_B = 11'h2AA;
  localparam logic [7:0]  UL_KEY_A  = 8'hAA;
  localparam logic [7:0]  UL_KEY_B  = 8'h55;
  localparam logic [7:0]  OP_SETUP  = 8'h80;
  localparam logic [7:0]  OP_CHIP   = 8'h10;
  localparam logic [7:0]  OP_SECT   = 8'h30;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_HOLD   = 8'hB0;

  typedef enum logic [3:0] {
    D_READ, D_UL1, D_UL2, D_PGM, D_SU1, D_SU2, D_SU3, D_WIN, D_BUSY
  } dec_st_t;

  typedef enum logic [2:0] {
    E_IDLE, E_PROG, E_SCAN, E_ZERO, E_ONE
  } eng_st_t;

  // bits may only be cleared by a program
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic pair_hit(input logic [10:0] a, input logic [7:0] d,
                                    input logic [10:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction
endpackage

// File: rtl/flash_wr_strobe.sv
module flash_wr_strobe #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [7:0]        ev_data
);
  logic act, act_q;
  logic [ADDR_W-1:0] a_q;

  assign act = ~ce_n & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      a_q   <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) a_q <= addr;   // address taken as the cycle opens
    end
  end

  // cycle closes when either strobe rises first
  assign ev_valid = act_q & ~act;
  assign ev_addr  = a_q;
  assign ev_data  = din;
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int MEM_AW  = 6,
  parameter int SECTORS = 4,
  parameter int WIN_CYC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [ADDR_W-1:0]  ev_addr,
  input  logic [7:0]         ev_data,
  input  logic               eng_busy,
  output logic               prog_go,
  output logic [MEM_AW-1:0]  prog_addr,
  output logic [7:0]         prog_data,
  output logic               erase_go,
  output logic [SECTORS-1:0] erase_mask,
  output logic               susp_req,
  output logic               resume_req,
  output logic               win_open
);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int TMR_W = $clog2(WIN_CYC + 1);

  dec_st_t st, st_n;
  logic [SECTORS-1:0] mask, mask_n, sec_bit;
  logic [TMR_W-1:0]   tmr, tmr_n;
  logic               is_sec, sec_n;
  logic [10:0]        ua;

  assign ua        = ev_addr[10:0];
  assign sec_bit   = {{(SECTORS-1){1'b0}}, 1'b1} << ev_addr[MEM_AW-1 -: SEC_W];
  assign prog_addr = ev_addr[MEM_AW-1:0];
  assign prog_data = ev_data;
  assign win_open  = (st == D_WIN);

  always_comb begin
    st_n = st; mask_n = mask; tmr_n = tmr; sec_n = is_sec;
    prog_go = 1'b0; erase_go = 1'b0; erase_mask = mask;
    susp_req = 1'b0; resume_req = 1'b0;
    case (st)
      D_READ: if (ev_valid && pair_hit(ua, ev_data, UL_ADDR_A, UL_KEY_A)) st_n = D_UL1;
      D_UL1:  if (ev_valid) st_n = pair_hit(ua, ev_data, UL_ADDR_B, UL_KEY_B) ? D_UL2 : D_READ;
      D_UL2:  if (ev_valid) begin
                if (pair_hit(ua, ev_data, UL_ADDR_A, OP_PROG))       st_n = D_PGM;
                else if (pair_hit(ua, ev_data, UL_ADDR_A, OP_SETUP)) st_n = D_SU1;
                else                                                 st_n = D_READ;
              end
      D_PGM:  if (ev_valid) begin
                prog_go = 1'b1; sec_n = 1'b0; st_n = D_BUSY;
              end
      D_SU1:  if (ev_valid) st_n = pair_hit(ua, ev_data, UL_ADDR_A, UL_KEY_A) ? D_SU2 : D_READ;
      D_SU2:  if (ev_valid) st_n = pair_hit(ua, ev_data, UL_ADDR_B, UL_KEY_B) ? D_SU3 : D_READ;
      D_SU3:  if (ev_valid) begin
                if (pair_hit(ua, ev_data, UL_ADDR_A, OP_CHIP)) begin
                  erase_go = 1'b1; erase_mask = '1; sec_n = 1'b0; st_n = D_BUSY;
                end else if (ev_data == OP_SECT) begin
                  mask_n = sec_bit; tmr_n = TMR_W'(WIN_CYC - 1); sec_n = 1'b1; st_n = D_WIN;
                end else st_n = D_READ;
              end
      D_WIN:  if (tmr == '0) begin
                erase_go = 1'b1; mask_n = '0; st_n = D_BUSY;
              end else if (ev_valid) begin
                if (ev_data == OP_SECT) begin
                  mask_n = mask | sec_bit; tmr_n = TMR_W'(WIN_CYC - 1);
                end else begin
                  mask_n = '0; st_n = D_READ;
                end
              end else tmr_n = tmr - 1'b1;
      D_BUSY: if (!eng_busy) st_n = D_READ;
              else if (ev_valid && is_sec) begin
                if (ev_data == OP_HOLD)      susp_req   = 1'b1;
                else if (ev_data == OP_SECT) resume_req = 1'b1;
              end
      default: st_n = D_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= D_READ; mask <= '0; tmr <= '0; is_sec <= 1'b0;
    end else begin
      st <= st_n; mask <= mask_n; tmr <= tmr_n; is_sec <= sec_n;
    end
  end
endmodule

// File: rtl/flash_engine.sv
module flash_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW   = 6,
  parameter int SECTORS  = 4,
  parameter int PROG_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_go,
  input  logic [MEM_AW-1:0]  prog_addr,
  input  logic [7:0]         prog_data,
  input  logic               erase_go,
  input  logic [SECTORS-1:0] erase_mask,
  input  logic               susp_req,
  input  logic               resume_req,
  input  logic [MEM_AW-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  output logic               busy,
  output logic               suspended,
  output logic               mem_we,
  output logic               ph_zero,
  output logic               ph_one
);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int IDX_W = MEM_AW - SEC_W;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PC_W  = $clog2(PROG_CYC + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = '1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECTORS - 1);

  eng_st_t st;
  logic [7:0]         mem [DEPTH];
  logic [MEM_AW-1:0]  pa, wa;
  logic [7:0]         pd, wd;
  logic [PC_W-1:0]    pcnt;
  logic [SECTORS-1:0] emask;
  logic [SEC_W-1:0]   cur;
  logic [IDX_W-1:0]   idx;
  logic               susp;

  always_comb begin
    mem_we = 1'b0; wa = {cur, idx}; wd = 8'h00;
    case (st)
      E_PROG: if (pcnt == '0) begin mem_we = 1'b1; wa = pa; wd = prog_merge(mem[pa], pd); end
      E_ZERO: if (!susp) begin mem_we = 1'b1; wd = 8'h00; end
      E_ONE:  if (!susp) begin mem_we = 1'b1; wd = 8'hFF; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[wa] <= wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; pa <= '0; pd <= '0; pcnt <= '0;
      emask <= '0; cur <= '0; idx <= '0;
    end else begin
      case (st)
        E_IDLE: if (prog_go) begin
                  st <= E_PROG; pa <= prog_addr; pd <= prog_data; pcnt <= PC_W'(PROG_CYC - 1);
                end else if (erase_go) begin
                  st <= E_SCAN; emask <= erase_mask; cur <= '0; idx <= '0;
                end
        E_PROG: if (pcnt == '0) st <= E_IDLE;
                else pcnt <= pcnt - 1'b1;
        E_SCAN: if (!susp) begin
                  if (emask[cur])           begin st <= E_ZERO; idx <= '0; end
                  else if (cur == SEC_LAST) st <= E_IDLE;
                  else                      cur <= cur + 1'b1;
                end
        E_ZERO: if (!susp) begin
                  if (idx == IDX_LAST) begin st <= E_ONE; idx <= '0; end
                  else idx <= idx + 1'b1;
                end
        E_ONE:  if (!susp) begin
                  if (idx == IDX_LAST) begin
                    idx <= '0;
                    if (cur == SEC_LAST) st <= E_IDLE;
                    else begin cur <= cur + 1'b1; st <= E_SCAN; end
                  end else idx <= idx + 1'b1;
                end
        default: st <= E_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          susp <= 1'b0;
    else if (st == E_IDLE)               susp <= 1'b0;
    else if (susp_req && st != E_PROG)   susp <= 1'b1;
    else if (resume_req)                 susp <= 1'b0;
  end

  assign rd_data   = mem[rd_addr];
  assign busy      = (st != E_IDLE);
  assign suspended = susp;
  assign ph_zero   = (st == E_ZERO);
  assign ph_one    = (st == E_ONE);
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
  parameter int ADDR_W   = 11,
  parameter int MEM_AW   = 6,
  parameter int SECTORS  = 4,
  parameter int PROG_CYC = 4,
  parameter int WIN_CYC  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy,
  output logic              win_open,
  output logic              suspended
);
  logic               ev_valid;
  logic [ADDR_W-1:0]  ev_addr;
  logic [7:0]         ev_data;
  logic               prog_go, erase_go, susp_req, resume_req;
  logic [MEM_AW-1:0]  prog_addr;
  logic [7:0]         prog_data, rd_data;
  logic [SECTORS-1:0] erase_mask;
  logic               mem_we, ph_zero, ph_one;

  flash_wr_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  flash_cmd_dec #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .SECTORS(SECTORS), .WIN_CYC(WIN_CYC)) u_dec (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
    .eng_busy(busy), .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_go(erase_go), .erase_mask(erase_mask), .susp_req(susp_req),
    .resume_req(resume_req), .win_open(win_open)
  );

  flash_engine #(.MEM_AW(MEM_AW), .SECTORS(SECTORS), .PROG_CYC(PROG_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_go(erase_go), .erase_mask(erase_mask), .susp_req(susp_req), .resume_req(resume_req),
    .rd_addr(addr[MEM_AW-1:0]), .rd_data(rd_data), .busy(busy), .suspended(suspended),
    .mem_we(mem_we), .ph_zero(ph_zero), .ph_one(ph_one)
  );

  assign dout = (!ce_n && !oe_n) ? rd_data : 8'h00;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic win_open,
  input logic suspended,
  input logic prog_go,
  input logic erase_go,
  input logic mem_we,
  input logic ph_zero,
  input logic ph_one
);
  a_r2_prog_busy: assert property (@(posedge clk) disable iff (!rst_n) prog_go |=> busy);
  a_r5_window_idle: assert property (@(posedge clk) disable iff (!rst_n) win_open |-> !busy);
  a_r9_susp_in_busy: assert property (@(posedge clk) disable iff (!rst_n) suspended |-> busy);
  a_r9_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && $past(suspended)) |-> !mem_we);
  a_r10_zero_before_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_one) |-> $past(ph_zero));
  a_r4_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);
  a_r8_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, erase_go}));
endmodule

bind flash_cmd_top flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .win_open(win_open), .suspended(suspended),
  .prog_go(prog_go), .erase_go(erase_go), .mem_we(mem_we), .ph_zero(ph_zero), .ph_one(ph_one)
);

// File: tb/flash_cmd_top_tb.sv
`timescale 1ns/1ps
module flash_cmd_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic busy, win_open, suspended;
  logic [7:0] mdl [64];
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  flash_cmd_top u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .din(din), .dout(dout), .busy(busy), .win_open(win_open), .suspended(suspended)
  );

  function automatic logic [7:0] pat1(input int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] pat2(input int i); return 8'(i ^ 8'h5A); endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic wr_late(input logic [10:0] a, input logic [10:0] a2, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = a2; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic wr_ce(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 v = dout;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic prog_cmd(input logic [10:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_setup();
    unlock(); wr(11'h555, 8'h80); unlock();
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while ((busy || win_open) && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin n_err++; n_chk++; $display("FAIL %s: still busy got 1 expected 0", tag); end
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 64; i++) begin rd(11'(i), v); check(tag, v, mdl[i]); end
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {7'b0, busy}, 8'h00);
    check("R1 win_open", {7'b0, win_open}, 8'h00);
    check("R1 suspended", {7'b0, suspended}, 8'h00);
    check("R1 dout idle", dout, 8'h00);
    sweep("R1 erased");

    // R2 program sweep
    for (int i = 0; i < 64; i++) begin
      prog_cmd(11'(i), pat1(i));
      if (i == 0) check("R2 busy after program", {7'b0, busy}, 8'h01);
      wait_done("R2");
      mdl[i] = mdl[i] & pat1(i);
    end
    sweep("R2 programmed");

    // R3 AND rule
    for (int i = 0; i < 64; i++) begin
      prog_cmd(11'(i), pat2(i));
      wait_done("R3");
      mdl[i] = mdl[i] & pat2(i);
    end
    sweep("R3 and-merge");

    // R4 broken unlock strings
    unlock(); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(11'd7, 8'h00);
    check("R4 busy", {7'b0, busy}, 8'h00);
    rd(11'd7, v); check("R4 addr7", v, mdl[7]);
    wr(11'h554, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'd9, 8'h00);
    check("R4 busy wrong addr", {7'b0, busy}, 8'h00);
    rd(11'd9, v); check("R4 addr9", v, mdl[9]);

    // R11 address taken at cycle open
    unlock(); wr(11'h555, 8'hA0); wr_late(11'd12, 11'd40, 8'h0F);
    wait_done("R11");
    mdl[12] = mdl[12] & 8'h0F;
    rd(11'd12, v); check("R11 target", v, mdl[12]);
    rd(11'd40, v); check("R11 other", v, mdl[40]);

    // R12 cycle closed by ce_n
    unlock(); wr(11'h555, 8'hA0); wr_ce(11'd20, 8'hF0);
    check("R12 busy", {7'b0, busy}, 8'h01);
    wait_done("R12");
    mdl[20] = mdl[20] & 8'hF0;
    rd(11'd20, v); check("R12 data", v, mdl[20]);

    // R5 / R6 sector erase with added sector
    erase_setup(); wr(11'd19, 8'h30);
    check("R5 window open", {7'b0, win_open}, 8'h01);
    wr(11'd55, 8'h30);
    check("R6 window still open", {7'b0, win_open}, 8'h01);
    wait_done("R5");
    for (int i = 16; i < 32; i++) mdl[i] = 8'hFF;
    for (int i = 48; i < 64; i++) mdl[i] = 8'hFF;
    sweep("R5 R6 sectors");

    // R7 cancel in window
    erase_setup(); wr(11'd5, 8'h30); wr(11'd5, 8'h00);
    check("R7 window closed", {7'b0, win_open}, 8'h00);
    check("R7 not busy", {7'b0, busy}, 8'h00);
    repeat (40) @(negedge clk);
    sweep("R7 unchanged");

    // R9 suspend / resume
    erase_setup(); wr(11'd32, 8'h30);
    while (win_open) @(negedge clk);
    check("R9 busy at start", {7'b0, busy}, 8'h01);
    wr(11'd0, 8'hB0);
    check("R9 suspended", {7'b0, suspended}, 8'h01);
    prog_cmd(11'd1, 8'h00);
    repeat (60) @(negedge clk);
    check("R9 still busy", {7'b0, busy}, 8'h01);
    check("R9 still suspended", {7'b0, suspended}, 8'h01);
    rd(11'd50, v); check("R9 other sector", v, mdl[50]);
    wr(11'd0, 8'h30);
    check("R9 resumed", {7'b0, suspended}, 8'h00);
    wait_done("R9");
    for (int i = 32; i < 48; i++) mdl[i] = 8'hFF;
    sweep("R9 after erase");

    // R8 / R10 chip erase
    erase_setup(); wr(11'h555, 8'h10);
    repeat (4) @(negedge clk);
    rd(11'd0, v); check("R10 pre-zero", v, 8'h00);
    check("R8 busy", {7'b0, busy}, 8'h01);
    wait_done("R8");
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    sweep("R8 chip erased");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule